// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between clocked on-chip logic and an external asynchronous static RAM of 256K sixteen-bit words. The memory has no clock. It is driven through active-low chip select, write enable, output enable and two byte-lane selects, and it shares one data bus between reading and writing. The controller turns a simple request/ready handshake into correctly timed strobe sequences. Every strobe phase length is derived at elaboration time from nanosecond timing figures and a clock-period parameter, always rounding up to whole cycles.

A client presents a word address, write data, a two-bit lane mask and a read/write flag. The request is taken in a cycle where ready is high. Ready stays low until the access has finished. Read data is registered. Lanes that the mask leaves out are returned as zero, and the data comes with a one-cycle valid strobe. The data bus is handled as three separate signals: drive value, drive enable and sampled input. Pad tristate buffers stay outside the block. After a read, a turnaround counter keeps the controller off the bus for long enough that the memory has let go of it before any write data is driven.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ready is 1, all five memory strobes are high, the bus drive enable is 0 and read-valid is 0.
- R2: An accepted read holds chip select and output enable low, with write enable high, for exactly N_RD cycles. The bus is sampled at the end of the last of those cycles. rd_data then shows that value with rd_valid high for exactly one cycle, the first cycle after the strobes rise.
- R3: An accepted write holds chip select and write enable low for exactly N_WP cycles, and output enable stays high throughout. The drive enable is high and mem_dq_o carries the request's write data from the first strobe cycle up to and including one cycle after write enable rises.
- R4: Mask bit 0 enables the lower lane (mem_lb_n, bits 7:0) and mask bit 1 enables the upper lane (mem_ub_n, bits 15:8); a set bit means enabled. The select of a disabled lane stays high for the whole access. A disabled lane therefore is not written and reads back as zero in rd_data. A mask of 00 leaves memory unchanged.
- R5: Ready is high only while the controller is idle. Exactly one memory access is made per accepted request. A request held high while ready is low is not accepted a second time.
- R6: Between the last cycle with output enable low and the first cycle of bus drive there are at least N_TA cycles, with output enable high and the drive enable low in all of them.
- R7: The address stays stable in every cycle where chip select is low.
- R8: When chip select is high, both lane selects are high. Output enable low and drive enable high never occur in the same cycle.
- R9: N_RD is the rounded-up cycle count of the largest of the read-cycle (55 ns), address-access (55 ns) and output-enable (30 ns) figures. N_WP is the largest of the rounded-up write-pulse (40 ns), select-to-end (50 ns) and data-setup (25 ns) figures and the write-cycle figure (55 ns) minus one cycle. N_TA is the rounded-up bus-release figure. With a 20 ns clock and a 45 ns release figure, all three are 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Registered read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_i | input | 16 | Data sampled from the bus |

## Verification
The interesting coincidence comes from a write request that arrives while the post-read turnaround count is still running, in the very cycle that the read's data is being returned. The bench provokes it by queueing a write straight behind a read with the release figure set to 45 ns, so that the controller must hold the accepted write in a waiting phase. It then judges at the ports that the read-data strobe appears once, with the right value, and that the cycles with output enable high before drive begins number at least the turnaround count. A behavioural memory model in the bench records what actually reaches the bus, and later reads compare against a separately kept expected image.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WHOLD = 3'd3,
        ST_READ  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } access_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/asram_capture.sv
module asram_capture
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [LANES-1:0]  cap_mask,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [7:0] lane_q [LANES];

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= cap_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else if (cap_en)
                lane_q[g] <= cap_mask[g] ? dq_i[8*g +: 8] : 8'h00;
        end
        assign rd_data[8*g +: 8] = lane_q[g];
    end

    // R2
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int N_RD = 3,
    parameter int N_WP = 3,
    parameter int N_TA = 1,
    parameter int PH_W = 2,
    parameter int TA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_bmask,
    input  logic [PH_W-1:0]   ph_cnt,
    input  logic [TA_W-1:0]   ta_cnt,
    output logic              ph_load,
    output logic [PH_W-1:0]   ph_val,
    output logic              ta_load,
    output logic [TA_W-1:0]   ta_val,
    output logic              req_ready,
    output logic              cap_en,
    output logic [LANES-1:0]  cap_mask,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_bsel_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    seq_state_t state, state_nx;
    access_t    acc;
    logic       bus_free;
    logic       active;

    assign bus_free = (ta_cnt <= TA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            acc   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid)
                acc <= '{write: req_write, addr: req_addr,
                         wdata: req_wdata, mask: req_bmask};
        end
    end

    always_comb begin
        state_nx = state;
        ph_load  = 1'b0;
        ph_val   = '0;
        ta_load  = 1'b0;
        ta_val   = TA_W'(N_TA);
        cap_en   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_nx = ST_READ;
                        ph_load  = 1'b1;
                        ph_val   = PH_W'(N_RD - 1);
                    end else if (bus_free) begin
                        state_nx = ST_WRITE;
                        ph_load  = 1'b1;
                        ph_val   = PH_W'(N_WP - 1);
                    end else begin
                        state_nx = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (bus_free) begin
                    state_nx = ST_WRITE;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(N_WP - 1);
                end
            end
            ST_WRITE: begin
                if (ph_cnt == '0) state_nx = ST_WHOLD;
            end
            ST_WHOLD: begin
                state_nx = ST_IDLE;
            end
            ST_READ: begin
                if (ph_cnt == '0) begin
                    state_nx = ST_IDLE;
                    cap_en   = 1'b1;
                    ta_load  = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign active     = (state == ST_WRITE) || (state == ST_READ);
    assign req_ready  = (state == ST_IDLE);
    assign mem_addr   = acc.addr;
    assign mem_cs_n   = !active;
    assign mem_we_n   = (state != ST_WRITE);
    assign mem_oe_n   = (state != ST_READ);
    assign mem_dq_o   = acc.wdata;
    assign mem_dq_oe  = (state == ST_WRITE) || (state == ST_WHOLD);
    assign cap_mask   = acc.mask;

    for (genvar g = 0; g < LANES; g++) begin : g_sel
        assign mem_bsel_n[g] = !(active && acc.mask[g]);
    end

    // R3
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
    // R8
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
    // R8
    standby_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_bsel_n == '1));
    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    // R5
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_dq_oe));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 30,
    parameter int T_WP_NS   = 40,
    parameter int T_SEL_NS  = 50,
    parameter int T_DS_NS   = 25,
    parameter int T_WC_NS   = 55,
    parameter int T_REL_NS  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_bmask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int N_RD = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS),
                               imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                    ns_to_cyc(T_OE_NS, CLK_NS))));
    localparam int N_WP = imax(1, imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                            ns_to_cyc(T_SEL_NS, CLK_NS)),
                               imax(ns_to_cyc(T_DS_NS, CLK_NS),
                                    ns_to_cyc(T_WC_NS, CLK_NS) - 1)));
    localparam int N_TA = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int PH_W = width_for(imax(N_RD, N_WP));
    localparam int TA_W = width_for(N_TA);
    localparam int RUN_W = width_for(imax(imax(N_RD, N_WP), N_TA) + 1);

    logic              ph_load, ta_load, cap_en;
    logic [PH_W-1:0]   ph_val, ph_cnt;
    logic [TA_W-1:0]   ta_val, ta_cnt;
    logic [LANES-1:0]  cap_mask, bsel_n;

    asram_cnt #(.W(PH_W)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .cnt(ph_cnt)
    );

    asram_cnt #(.W(TA_W)) u_turn (
        .clk(clk), .rst(rst), .load(ta_load), .load_val(ta_val), .cnt(ta_cnt)
    );

    asram_seq #(
        .N_RD(N_RD), .N_WP(N_WP), .N_TA(N_TA), .PH_W(PH_W), .TA_W(TA_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_bmask(req_bmask),
        .ph_cnt(ph_cnt), .ta_cnt(ta_cnt),
        .ph_load(ph_load), .ph_val(ph_val), .ta_load(ta_load), .ta_val(ta_val),
        .req_ready(req_ready), .cap_en(cap_en), .cap_mask(cap_mask),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_bsel_n(bsel_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );

    asram_capture u_cap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_mask(cap_mask),
        .dq_i(mem_dq_i), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign mem_lb_n = bsel_n[0];
    assign mem_ub_n = bsel_n[1];

    // Port-level run counters used only by the checks below.
    logic [RUN_W-1:0] we_run, oe_idle_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run      <= '0;
            oe_idle_run <= RUN_W'(N_TA);
        end else begin
            we_run <= !mem_we_n ? we_run + RUN_W'(1) : '0;
            if (!mem_oe_n)
                oe_idle_run <= '0;
            else if (oe_idle_run < RUN_W'(N_TA))
                oe_idle_run <= oe_idle_run + RUN_W'(1);
        end
    end

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run == RUN_W'(N_WP)));
    // R6
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_idle_run >= RUN_W'(N_TA)));
    // R3
    data_held_after_we_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

    localparam int CLK_NS = 20;
    localparam int REL_NS = 45;

    function automatic int cu(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD = mx(cu(55), mx(cu(55), cu(30)));
    localparam int E_WP = mx(mx(cu(40), cu(50)), mx(cu(25), cu(55) - 1));
    localparam int E_TA = cu(REL_NS);

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [17:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_bmask;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o, mem_dq_i;

    always #10 clk = ~clk;

    asram_ctrl #(.CLK_NS(CLK_NS), .T_REL_NS(REL_NS)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    typedef struct {
        bit          wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
    } item_t;

    item_t       aq[$];
    logic [15:0] rq[$];
    logic [15:0] shadow [logic [17:0]];
    logic [15:0] mdl    [logic [17:0]];
    int          n_chk = 0;
    int          n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mdl_word(input logic [17:0] a);
        return mdl.exists(a) ? mdl[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] sh_word(input logic [17:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    // Behavioural memory: drives only enabled lanes, junk elsewhere.
    always_comb begin
        logic [15:0] w;
        w = mdl_word(mem_addr);
        if (!mem_cs_n && !mem_oe_n)
            mem_dq_i = {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
        else
            mem_dq_i = 16'hDEAD;
    end

    // Driver: expected items are pushed at issue time.
    task automatic do_req(input bit wr, input logic [17:0] a,
                          input logic [15:0] d, input logic [1:0] m);
        item_t it;
        logic [15:0] w;
        it.wr = wr; it.addr = a; it.data = d; it.mask = m;
        aq.push_back(it);
        w = sh_word(a);
        if (wr) begin
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            shadow[a] = w;
        end else begin
            rq.push_back({m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00});
        end
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata = d;    req_bmask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor state
    item_t cur;
    logic  p_cs = 1'b1, p_rdv = 1'b0, p_dqoe = 1'b0;
    logic [17:0] p_addr = '0;
    int    we_run = 0, rd_run = 0, since_oe = 100, after_we = 0;
    bit    mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            // access start
            if (p_cs && !mem_cs_n) begin
                if (aq.size() == 0) begin
                    check(1'b0, "R5", "access without request", 1, 0);
                    cur = '{wr: 1'b0, addr: '0, data: '0, mask: '0};
                end else begin
                    cur = aq.pop_front();
                    check(mem_addr == cur.addr, "R7", "addr", mem_addr, cur.addr);
                    check(mem_we_n == !cur.wr, "R2", "direction", mem_we_n, !cur.wr);
                    check(mem_lb_n == !cur.mask[0], "R4", "lower select", mem_lb_n, !cur.mask[0]);
                    check(mem_ub_n == !cur.mask[1], "R4", "upper select", mem_ub_n, !cur.mask[1]);
                end
            end
            if (!mem_cs_n) begin
                check(!req_ready, "R5", "ready during access", req_ready, 0);
                if (!p_cs)
                    check(mem_addr == p_addr, "R7", "addr stable", mem_addr, p_addr);
            end
            if (mem_cs_n)
                check(mem_lb_n && mem_ub_n, "R8", "lanes in standby",
                      {mem_ub_n, mem_lb_n}, 2'b11);
            // bus drive start: turnaround gap
            if (!p_dqoe && mem_dq_oe)
                check(since_oe >= E_TA, "R6", "turnaround cycles", since_oe, E_TA);
            // write cycles
            if (!mem_cs_n && !mem_we_n) begin
                we_run++;
                check(mem_oe_n && mem_dq_oe && mem_dq_o == cur.data, "R3",
                      "write drive", mem_dq_o, cur.data);
                begin
                    logic [15:0] w;
                    w = mdl_word(mem_addr);
                    if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
                    if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
                    mdl[mem_addr] = w;
                end
            end
            if (!mem_cs_n && !mem_oe_n) begin
                rd_run++;
                check(!mem_dq_oe && mem_we_n, "R8", "no drive while reading", mem_dq_oe, 0);
            end
            // access end
            if (!p_cs && mem_cs_n) begin
                if (cur.wr) begin
                    check(we_run == E_WP, "R9", "write pulse cycles", we_run, E_WP);
                    check(mem_dq_oe && mem_dq_o == cur.data, "R3", "data hold",
                          mem_dq_o, cur.data);
                end else begin
                    check(rd_run == E_RD, "R9", "read strobe cycles", rd_run, E_RD);
                end
                we_run = 0; rd_run = 0;
            end
            // read data
            if (rd_valid) begin
                check(!p_rdv, "R2", "valid width", 2, 1);
                if (rq.size() == 0)
                    check(1'b0, "R2", "unexpected rd_valid", 1, 0);
                else begin
                    logic [15:0] e;
                    e = rq.pop_front();
                    check(rd_data == e, "R2", "read data", rd_data, e);
                end
            end
            since_oe = !mem_oe_n ? 0 : since_oe + 1;
            p_cs = mem_cs_n; p_rdv = rd_valid; p_dqoe = mem_dq_oe; p_addr = mem_addr;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_bmask = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(req_ready && mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
              && !mem_dq_oe && !rd_valid, "R1", "reset outputs",
              {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
               mem_dq_oe, rd_valid}, 8'b11111100);
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after reset
        check(req_ready && mem_cs_n && !mem_dq_oe && !rd_valid, "R1",
              "idle after reset", {req_ready, mem_cs_n, mem_dq_oe, rd_valid}, 4'b1100);
        mon_on = 1'b1;

        // R3 / R2 full word
        do_req(1'b1, 18'h00005, 16'hA5C3, 2'b11);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b11);
        // R4 lower only, then upper only, then reads
        do_req(1'b1, 18'h00005, 16'h1177, 2'b01);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b11);
        do_req(1'b1, 18'h00005, 16'h3399, 2'b10);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b11);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b10);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b01);
        // R4 empty mask leaves memory untouched
        do_req(1'b1, 18'h00005, 16'hFFFF, 2'b00);
        do_req(1'b0, 18'h00005, 16'h0000, 2'b11);
        // R6 read straight into write, top address
        do_req(1'b1, 18'h3FFFF, 16'h0F0F, 2'b11);
        do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_req(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11);
        do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_req(1'b0, 18'h00000, 16'h0000, 2'b11);
        // several patterns, back to back
        for (int i = 0; i < 6; i++)
            do_req(1'b1, 18'(i * 18'h0A3C1), 16'(i * 16'h2345) ^ 16'h5A5A, 2'b11);
        for (int i = 0; i < 6; i++) begin
            do_req(1'b0, 18'(i * 18'h0A3C1), 16'h0000, 2'b11);
            do_req(1'b1, 18'(i * 18'h0A3C1), 16'(16'hC000 + i), 2'(i % 3 + 1));
        end
        for (int i = 0; i < 6; i++)
            do_req(1'b0, 18'(i * 18'h0A3C1), 16'h0000, 2'b11);

        repeat (12) @(negedge clk);
        // R5 every request gave exactly one access and one reply
        check(aq.size() == 0, "R5", "accesses outstanding", aq.size(), 0);
        check(rq.size() == 0, "R2", "reads outstanding", rq.size(), 0);
        check(req_ready && mem_cs_n, "R5", "idle at end", {req_ready, mem_cs_n}, 2'b11);
        finish_run();
    end
endmodule